// File: doc/BRIEF.md
# Correlating Two-Bit Branch Predictor

This block guesses whether a conditional branch will be taken and learns from the real outcome on the same clock edge. A request presents the branch address, the resolved direction and an enable strobe. The block looks up a two-bit saturating counter, predicts taken when the counter is in one of its two upper states, and reports whether that guess was wrong. On the same edge it moves the counter one step towards the real outcome and shifts the outcome into a global history register. One branch can be accepted on every clock.

The table address is formed by placing the low bits of the global history above a field of the branch address. That field starts just above a configurable number of low address bits that are always zero for aligned instructions. Because the history sits in the upper index bits, a branch can learn different behaviour depending on how recent branches went. The parameters `HIST_W = 7` and `IDX_ADDR_W = 7` give a 16384-entry table. The defaults are smaller so the block stays light when it is elaborated on its own. Running totals of predictions and mispredictions are provided as 32-bit outputs.

Each counter is a four-state machine. The states are `CTR_SNT` (0, strongly not-taken), `CTR_WNT` (1, weakly not-taken), `CTR_WT` (2, weakly taken) and `CTR_ST` (3, strongly taken). The transitions are:
- `inc`, on a taken outcome: SNT→WNT→WT→ST, and ST stays ST.
- `dec`, on a not-taken outcome: ST→WT→WNT→SNT, and SNT stays SNT.

Top module: `corr_bpred`

## Requirements
- R1: After reset every counter is in state 0 (`CTR_SNT`), the history is zero, and `rsp_valid`, `rsp_taken`, `rsp_miss`, `pred_count` and `miss_count` are all 0.
- R2: The table index is `{hist[HIST_W-1:0], br_addr[LO_ZERO+IDX_ADDR_W-1:LO_ZERO]}`, with the history in the upper bits.
- R3: The prediction is taken (`rsp_taken = 1`) when the indexed counter value is 2 or 3, and not-taken when it is 0 or 1.
- R4: `rsp_miss` is 1 exactly when `rsp_taken` differs from the `br_taken` of the same request.
- R5: Each request with `br_en = 1` at a clock edge produces `rsp_valid = 1` together with its result after that edge, for one cycle per request. Back-to-back requests are allowed.
- R6: A taken outcome moves the indexed counter up by one, stopping at 3.
- R7: A not-taken outcome moves the indexed counter down by one, stopping at 0.
- R8: After every request the history shifts left by one and `br_taken` enters bit 0. The lookup for a request uses the history from before that request's own shift.
- R9: A cycle with `br_en = 0` changes no counter, no history bit and no total, and it gives `rsp_valid = 0`.
- R10: `pred_count` rises by one for each request, and `miss_count` rises by one for each request whose `rsp_miss` is 1. Both update on the same edge as the response.
- R11: Address bits below `LO_ZERO` and above the index field have no effect on the prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| br_en | input | 1 | A resolved branch is presented this cycle |
| br_addr | input | ADDR_IN_W | Branch instruction address |
| br_taken | input | 1 | Resolved direction, 1 = taken |
| rsp_valid | output | 1 | Result of the previous cycle's request is valid |
| rsp_taken | output | 1 | Predicted direction |
| rsp_miss | output | 1 | Prediction disagreed with the outcome |
| pred_count | output | CNT_W | Total requests since reset |
| miss_count | output | CNT_W | Total mispredictions since reset |

## Verification
A counter stuck in the wrong state, or one that steps the wrong way, shows up at the next request that maps to the same table entry. It appears as a flipped `rsp_taken` and `rsp_miss`, one cycle after that request. A corrupted history bit moves later lookups to a different entry, so it shows up within a few requests as a wrong prediction. Errors in the totals are visible on the very next response edge. The bench uses a 16-entry configuration, which lets one sweep of all addresses and all outcome patterns visit every entry and every counter state.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_state_e;

    // next state of a counter given the resolved direction
    function automatic ctr_state_e ctr_next(input ctr_state_e cur, input logic taken);
        ctr_state_e nxt;
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
            default: nxt = CTR_SNT;
        endcase
        return nxt;
    endfunction

    // upper two states predict taken
    function automatic logic ctr_predict(input ctr_state_e cur);
        logic p;
        unique case (cur)
            CTR_WT, CTR_ST:   p = 1'b1;
            CTR_SNT, CTR_WNT: p = 1'b0;
            default:          p = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/bpred_index.sv
module bpred_index #(
    parameter int ADDR_IN_W  = 32,
    parameter int HIST_W     = 5,
    parameter int IDX_ADDR_W = 5,
    parameter int LO_ZERO    = 2,
    parameter int IDX_W      = HIST_W + IDX_ADDR_W
) (
    input  logic [ADDR_IN_W-1:0] addr,
    input  logic [HIST_W-1:0]    hist,
    output logic [IDX_W-1:0]     idx
);
    // history above, aligned address field below
    assign idx = {hist, addr[LO_ZERO +: IDX_ADDR_W]};
endmodule

// File: rtl/bpred_history.sv
module bpred_history #(
    parameter int HIST_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              taken,
    output logic [HIST_W-1:0] hist
);
    always_ff @(posedge clk) begin
        if (rst)     hist <= '0;
        else if (en) hist <= {hist[HIST_W-2:0], taken};
    end

    // R8
    hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en)) |-> hist[0] == $past(taken));

    // R9
    hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(en)) |-> $stable(hist));
endmodule

// File: rtl/bpred_ctr_table.sv
module bpred_ctr_table
    import bpred_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    input  logic             taken,
    output ctr_state_e       rd_state
);
    ctr_state_e mem [DEPTH];

    assign rd_state = mem[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_SNT;
        end else if (en) begin
            mem[idx] <= ctr_next(rd_state, taken);
        end
    end

    // R6
    top_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (en && taken && rd_state == CTR_ST) |=> mem[$past(idx)] == CTR_ST);

    // R7
    bottom_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !taken && rd_state == CTR_SNT) |=> mem[$past(idx)] == CTR_SNT);
endmodule

// File: rtl/bpred_stats.sv
module bpred_stats #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             miss,
    output logic [CNT_W-1:0] pred_count,
    output logic [CNT_W-1:0] miss_count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pred_count <= '0;
            miss_count <= '0;
        end else if (en) begin
            pred_count <= pred_count + 1'b1;
            if (miss) miss_count <= miss_count + 1'b1;
        end
    end

    // R10
    miss_bound_chk: assert property (@(posedge clk) disable iff (rst)
        miss_count <= pred_count);

    // R10
    pred_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en)) |-> pred_count == $past(pred_count) + 1'b1);
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
    import bpred_pkg::*;
#(
    parameter int ADDR_IN_W  = 32,
    parameter int HIST_W     = 5,
    parameter int IDX_ADDR_W = 5,
    parameter int LO_ZERO    = 2,
    parameter int CNT_W      = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 br_en,
    input  logic [ADDR_IN_W-1:0] br_addr,
    input  logic                 br_taken,
    output logic                 rsp_valid,
    output logic                 rsp_taken,
    output logic                 rsp_miss,
    output logic [CNT_W-1:0]     pred_count,
    output logic [CNT_W-1:0]     miss_count
);
    localparam int IDX_W = HIST_W + IDX_ADDR_W;

    logic [HIST_W-1:0] hist;
    logic [IDX_W-1:0]  idx;
    ctr_state_e        cur_state;
    logic              guess;
    logic              wrong;

    bpred_index #(
        .ADDR_IN_W(ADDR_IN_W), .HIST_W(HIST_W),
        .IDX_ADDR_W(IDX_ADDR_W), .LO_ZERO(LO_ZERO), .IDX_W(IDX_W)
    ) u_index (
        .addr(br_addr), .hist(hist), .idx(idx)
    );

    bpred_history #(.HIST_W(HIST_W)) u_history (
        .clk(clk), .rst(rst), .en(br_en), .taken(br_taken), .hist(hist)
    );

    bpred_ctr_table #(.IDX_W(IDX_W)) u_table (
        .clk(clk), .rst(rst), .en(br_en), .idx(idx),
        .taken(br_taken), .rd_state(cur_state)
    );

    assign guess = ctr_predict(cur_state);
    assign wrong = guess ^ br_taken;

    bpred_stats #(.CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst(rst), .en(br_en), .miss(wrong),
        .pred_count(pred_count), .miss_count(miss_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_taken <= 1'b0;
            rsp_miss  <= 1'b0;
        end else begin
            rsp_valid <= br_en;
            rsp_taken <= br_en & guess;
            rsp_miss  <= br_en & wrong;
        end
    end

    // R5
    rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> rsp_valid == $past(br_en));

    // R4
    miss_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rsp_valid) |-> rsp_miss == (rsp_taken != $past(br_taken)));

    // R3
    upper_state_chk: assert property (@(posedge clk) disable iff (rst)
        (br_en && cur_state == CTR_ST) |=> rsp_taken);
endmodule

// File: tb/test_corr_bpred.sv
module test_corr_bpred;
    localparam int AW = 8;
    localparam int HW = 2;
    localparam int IW = 2;
    localparam int LO = 1;
    localparam int CW = 32;
    localparam int NENT = 1 << (HW + IW);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic br_en = 1'b0;
    logic [AW-1:0] br_addr = '0;
    logic br_taken = 1'b0;
    logic rsp_valid, rsp_taken, rsp_miss;
    logic [CW-1:0] pred_count, miss_count;

    always #2 clk = ~clk;

    corr_bpred #(
        .ADDR_IN_W(AW), .HIST_W(HW), .IDX_ADDR_W(IW), .LO_ZERO(LO), .CNT_W(CW)
    ) i_corr_bpred (
        .clk(clk), .rst(rst), .br_en(br_en), .br_addr(br_addr), .br_taken(br_taken),
        .rsp_valid(rsp_valid), .rsp_taken(rsp_taken), .rsp_miss(rsp_miss),
        .pred_count(pred_count), .miss_count(miss_count)
    );

    int n_chk = 0;
    int n_fail = 0;
    int ref_tbl [NENT];
    int ref_hist;
    int ref_pred;
    int ref_miss;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NENT; i++) ref_tbl[i] = 0;
        ref_hist = 0;
        ref_pred = 0;
        ref_miss = 0;
    endtask

    // called at a falling edge; drives one request and checks its result
    task automatic do_branch(input logic [AW-1:0] a, input logic tk, input string tag);
        int idx;
        logic et, em;
        idx = (ref_hist << IW) | ((int'(a) >> LO) & ((1 << IW) - 1));
        et = ref_tbl[idx] >= 2;
        em = et != tk;
        if (tk && ref_tbl[idx] < 3) ref_tbl[idx]++;
        if (!tk && ref_tbl[idx] > 0) ref_tbl[idx]--;
        ref_hist = ((ref_hist << 1) | int'(tk)) & ((1 << HW) - 1);
        ref_pred++;
        if (em) ref_miss++;
        br_en = 1'b1;
        br_addr = a;
        br_taken = tk;
        @(negedge clk);
        chk({tag, " R5 valid"}, {31'd0, rsp_valid}, 32'd1);
        chk({tag, " R3 taken"}, {31'd0, rsp_taken}, {31'd0, et});
        chk({tag, " R4 miss"}, {31'd0, rsp_miss}, {31'd0, em});
        chk({tag, " R10 pred_count"}, pred_count, ref_pred);
        chk({tag, " R10 miss_count"}, miss_count, ref_miss);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            br_en = 1'b0;
            br_addr = 8'hFF;
            br_taken = 1'b1;
            @(negedge clk);
            chk("R9 idle valid", {31'd0, rsp_valid}, 32'd0);
            chk("R9 idle pred_count", pred_count, ref_pred);
        end
    endtask

    task automatic do_reset();
        br_en = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
        chk("R1 valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 taken", {31'd0, rsp_taken}, 32'd0);
        chk("R1 miss", {31'd0, rsp_miss}, 32'd0);
        chk("R1 pred_count", pred_count, 32'd0);
        chk("R1 miss_count", miss_count, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R6: six taken at one address, then a not-taken still predicts taken
        for (int k = 0; k < 6; k++) do_branch(8'h00, 1'b1, "R6 train");
        do_branch(8'h00, 1'b0, "R6 sat");
        chk("R6 strong state survives one dec", {31'd0, rsp_taken}, 32'd1);
        idle(1);

        // R7: many not-taken, then taken must still predict not-taken
        do_reset();
        for (int k = 0; k < 5; k++) do_branch(8'h10, 1'b0, "R7 train");
        do_branch(8'h10, 1'b1, "R7 sat");
        chk("R7 floor holds", {31'd0, rsp_taken}, 32'd0);

        // R11: same field, other bits differ
        do_reset();
        for (int k = 0; k < 5; k++) do_branch(8'h02, 1'b1, "R11 train");
        do_branch(8'h03, 1'b1, "R11 low bit");
        chk("R11 low bit ignored", {31'd0, rsp_taken}, 32'd1);
        do_branch(8'hFA, 1'b1, "R11 high bits");
        chk("R11 high bits ignored", {31'd0, rsp_taken}, 32'd1);
        do_branch(8'h04, 1'b1, "R2 other field");
        chk("R2 different entry", {31'd0, rsp_taken}, 32'd0);

        // R2 R8: exhaustive addresses x four-outcome patterns
        do_reset();
        for (int a = 0; a < 32; a++) begin
            for (int p = 0; p < 16; p++) begin
                for (int b = 0; b < 4; b++)
                    do_branch(AW'(a * 7), p[b], "R2 R8 sweep");
            end
            if (a % 8 == 0) idle(2);
        end

        // pseudo-random stream with R9 gaps
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'h0) idle(1);
            else do_branch(lfsr[11:4], lfsr[1] | lfsr[6], "R6 R7 R8 random");
        end
        idle(1);
        do_reset();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule